// File: doc/BRIEF.md
# Descriptor Ring Prefetch Cache

This block keeps a small local window onto a circular ring of 16-byte descriptors that lives in host memory. Software programs a base address, a ring size in bytes and a starting head index. After that the block reads descriptors ahead of a packet engine, up to the tail index that software advances. The packet engine consumes cached descriptors one at a time. It then asks for the consumed ones to be written back, giving an alignment mask with each request. The head index moves forward each time a writeback finishes.

Memory traffic goes through two request/done channels, one for reads and one for writes. Each carries a byte address and a byte count. At most one read and one write are in flight at a time. The cache tracks only occupancy (unused and used entries). The contents of the descriptors are handled elsewhere.

If software writes the ring configuration while the cache holds used entries or has a transfer outstanding, that is flagged. The new configuration is applied in either case, after the cache has been emptied.

Top module: `desc_ring_cache`

## Requirements
- R1: Ring length in descriptors is the byte-size register shifted right by 4. When the tail index is at or beyond the fetch pointer, a fetch asks for tail minus fetch pointer entries.
- R2: When the tail is below the fetch pointer, a fetch asks for ring length minus fetch pointer entries, so it stops at the end of the ring. The fetch pointer returns to 0 when it reaches the ring length after a completion.
- R3: The fetch count is further limited to CAP minus the used and unused entries now held. Used plus unused never exceeds CAP.
- R4: No read is issued when the count is zero or when a read is already outstanding.
- R5: A request presents byte address base + index*16 and byte count entries*16. The request holds address and count stable until its done pulse.
- R6: The writeback count starts as the number of used entries. If head plus that count is at least the ring length, the count becomes ring length minus head. Otherwise, with a nonzero mask, the mask bits are cleared from the count. No write is issued for a count of 0.
- R7: On write done, head advances by the written count modulo the ring length, and the used entries written are gone from the cache.
- R8: A flush that arrives during an outstanding write with a mask numerically smaller than the one in use is recorded. It is reissued with that mask once the write completes. A flush with a mask that is not smaller has no effect.
- R9: A consume pulse moves one entry from unused to used. It is ignored when no unused entry exists.
- R10: A configuration write while used entries exist or a transfer is outstanding makes cfg_err_o high for exactly one cycle. Every configuration write empties the cache, drops outstanding requests, loads head and sets the fetch pointer to the new head.
- R11: After reset, both requests are low, head, unused and used are 0, and cfg_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_base_i | input | ADDR_W | Ring base byte address |
| cfg_len_i | input | IDX_W+4 | Ring size in bytes |
| cfg_head_i | input | IDX_W | Starting head index |
| tail_i | input | IDX_W | Software tail index |
| consume_i | input | 1 | Engine takes one cached descriptor |
| flush_i | input | 1 | Writeback request |
| flush_mask_i | input | IDX_W | Alignment mask of the writeback request |
| rd_req_o | output | 1 | Read burst request |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_bytes_o | output | CNT_W+4 | Read byte count |
| rd_done_i | input | 1 | Read completion pulse |
| wr_req_o | output | 1 | Write burst request |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_bytes_o | output | CNT_W+4 | Write byte count |
| wr_done_i | input | 1 | Write completion pulse |
| head_o | output | IDX_W | Current head index |
| unused_o | output | CNT_W | Cached entries not yet consumed |
| used_o | output | CNT_W | Consumed entries not yet written back |
| cfg_err_o | output | 1 | Illegal configuration change pulse |

## Verification
Fetch sizing is swept over every head and tail pair of a 10-entry ring with a 4-entry cache. This separates the straight case, the case that stops at the ring end and the case limited by cache room. Writeback sizing is swept over every head, used count from 1 to 4 and masks 0, 1 and 3. This separates clamping at the ring end from rounding down by the mask, including round-downs to zero. Directed sequences then cover a smaller mask arriving mid-write against one that is not smaller, a fetch split by the wrap, ignored consumes, and configuration writes made with and without outstanding state.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int unsigned DESC_LG = 4;  // 16-byte descriptors
endpackage

// File: rtl/drc_fetch.sv
module drc_fetch #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CAP    = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_ptr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [CNT_W-1:0]  used_i,
  input  logic [CNT_W-1:0]  unused_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W+3:0]  bytes_o,
  output logic              fill_o,
  output logic [CNT_W-1:0]  fill_cnt_o
);
  import drc_pkg::*;
  localparam int unsigned W = IDX_W + 1;

  logic [IDX_W-1:0]  ptr_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]      want, room, take, nxt;
  logic              go;

  always_comb begin
    if (tail_i >= ptr_q) want = W'(tail_i - ptr_q);
    else                 want = W'(len_i - ptr_q);
    room = W'(CAP) - W'(used_i) - W'(unused_i);
    take = (want < room) ? want : room;
    go   = !busy_q && !clr_i && (len_i != '0) && (take != '0);
    nxt  = W'(ptr_q) + W'(cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (clr_i) begin
      ptr_q  <= clr_ptr_i;
      busy_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= take[CNT_W-1:0];
      addr_q <= base_i + (ADDR_W'(ptr_q) << DESC_LG);
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
      ptr_q  <= (nxt == W'(len_i)) ? '0 : nxt[IDX_W-1:0];
    end
  end

  assign req_o      = busy_q;
  assign addr_o     = addr_q;
  assign bytes_o    = {cnt_q, 4'b0000};
  assign fill_o     = busy_q && done_i && !clr_i;
  assign fill_cnt_o = cnt_q;
endmodule

// File: rtl/drc_wback.sv
module drc_wback #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_head_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  used_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  mask_i,
  input  logic              done_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W+3:0]  bytes_o,
  output logic              take_o,
  output logic [CNT_W-1:0]  take_cnt_o,
  output logic [IDX_W-1:0]  head_o
);
  import drc_pkg::*;
  localparam int unsigned W = IDX_W + 1;

  logic [IDX_W-1:0]  head_q, align_q, m;
  logic              busy_q, pend_q, ask, go;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]      cnt, hn;

  always_comb begin
    ask = flush_i || pend_q;
    m   = flush_i ? mask_i : align_q;
    cnt = W'(used_i);
    if (W'(head_q) + cnt >= W'(len_i)) cnt = W'(len_i) - W'(head_q);
    else if (m != '0)                  cnt = cnt & ~W'(m);
    go  = !busy_q && !clr_i && ask && (len_i != '0) && (cnt != '0);
    hn  = W'(head_q) + W'(cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      align_q <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else if (clr_i) begin
      head_q  <= clr_head_i;
      align_q <= '0;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (busy_q && flush_i && (mask_i < align_q)) begin
        pend_q  <= 1'b1;
        align_q <= mask_i;
      end
      if (!busy_q && ask) begin
        pend_q  <= 1'b0;
        align_q <= m;
      end
      if (go) begin
        busy_q <= 1'b1;
        cnt_q  <= cnt[CNT_W-1:0];
        addr_q <= base_i + (ADDR_W'(head_q) << DESC_LG);
      end
      if (busy_q && done_i) begin
        busy_q <= 1'b0;
        head_q <= (hn >= W'(len_i)) ? '0 : hn[IDX_W-1:0];
      end
    end
  end

  assign req_o      = busy_q;
  assign addr_o     = addr_q;
  assign bytes_o    = {cnt_q, 4'b0000};
  assign take_o     = go;
  assign take_cnt_o = cnt[CNT_W-1:0];
  assign head_o     = head_q;
endmodule

// File: rtl/drc_occ.sv
module drc_occ #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             consume_i,
  input  logic             fill_i,
  input  logic [CNT_W-1:0] fill_cnt_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] take_cnt_i,
  output logic [CNT_W-1:0] unused_o,
  output logic [CNT_W-1:0] used_o
);
  logic [CNT_W-1:0] unused_q, used_q, add, sub;
  logic             cons;

  always_comb begin
    cons = consume_i && (unused_q != '0) && !clr_i;
    add  = fill_i ? fill_cnt_i : '0;
    sub  = take_i ? take_cnt_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unused_q <= '0;
      used_q   <= '0;
    end else if (clr_i) begin
      unused_q <= '0;
      used_q   <= '0;
    end else begin
      unused_q <= unused_q - CNT_W'(cons) + add;
      used_q   <= used_q + CNT_W'(cons) - sub;
    end
  end

  assign unused_o = unused_q;
  assign used_o   = used_q;
endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CAP    = 8,
  localparam int unsigned CNT_W = $clog2(CAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [IDX_W+3:0]  cfg_len_i,
  input  logic [IDX_W-1:0]  cfg_head_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic              consume_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_mask_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W+3:0]  rd_bytes_o,
  input  logic              rd_done_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CNT_W+3:0]  wr_bytes_o,
  input  logic              wr_done_i,
  output logic [IDX_W-1:0]  head_o,
  output logic [CNT_W-1:0]  unused_o,
  output logic [CNT_W-1:0]  used_o,
  output logic              cfg_err_o
);
  import drc_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  len_q;
  logic              err_q;
  logic              fill, take;
  logic [CNT_W-1:0]  fill_cnt, take_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= cfg_we_i && ((used_o != '0) || rd_req_o || wr_req_o);
      if (cfg_we_i) begin
        base_q <= cfg_base_i;
        len_q  <= cfg_len_i[IDX_W+3:DESC_LG];
      end
    end
  end

  drc_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP), .CNT_W(CNT_W)) u_fetch (
    .clk_i, .rst_ni,
    .clr_i      (cfg_we_i),
    .clr_ptr_i  (cfg_head_i),
    .base_i     (base_q),
    .len_i      (len_q),
    .tail_i,
    .used_i     (used_o),
    .unused_i   (unused_o),
    .done_i     (rd_done_i),
    .req_o      (rd_req_o),
    .addr_o     (rd_addr_o),
    .bytes_o    (rd_bytes_o),
    .fill_o     (fill),
    .fill_cnt_o (fill_cnt)
  );

  drc_wback #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wback (
    .clk_i, .rst_ni,
    .clr_i      (cfg_we_i),
    .clr_head_i (cfg_head_i),
    .base_i     (base_q),
    .len_i      (len_q),
    .used_i     (used_o),
    .flush_i,
    .mask_i     (flush_mask_i),
    .done_i     (wr_done_i),
    .req_o      (wr_req_o),
    .addr_o     (wr_addr_o),
    .bytes_o    (wr_bytes_o),
    .take_o     (take),
    .take_cnt_o (take_cnt),
    .head_o
  );

  drc_occ #(.CNT_W(CNT_W)) u_occ (
    .clk_i, .rst_ni,
    .clr_i      (cfg_we_i),
    .consume_i,
    .fill_i     (fill),
    .fill_cnt_i (fill_cnt),
    .take_i     (take),
    .take_cnt_i (take_cnt),
    .unused_o,
    .used_o
  );

  assign cfg_err_o = err_q;
endmodule

// File: rtl/drc_chk.sv
module drc_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAP    = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [CNT_W+3:0]  rd_bytes_o,
  input logic              rd_done_i,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [CNT_W+3:0]  wr_bytes_o,
  input logic              wr_done_i,
  input logic [CNT_W-1:0]  unused_o,
  input logic [CNT_W-1:0]  used_o,
  input logic              cfg_err_o
);
  assert_rd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_done_i && !cfg_we_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_bytes_o));

  assert_wr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_done_i && !cfg_we_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_bytes_o));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(used_o) + int'(unused_o)) <= int'(CAP));

  assert_fetch_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> (int'(used_o) + int'(unused_o) + int'(rd_bytes_o >> 4)) <= int'(CAP));

  assert_rd_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_bytes_o != '0);

  assert_wr_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_bytes_o != '0);

  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !cfg_err_o);
endmodule

bind desc_ring_cache drc_chk #(.ADDR_W(ADDR_W), .CAP(CAP), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i,
  .rd_req_o, .rd_addr_o, .rd_bytes_o, .rd_done_i,
  .wr_req_o, .wr_addr_o, .wr_bytes_o, .wr_done_i,
  .unused_o, .used_o, .cfg_err_o
);

// File: tb/sim_desc_ring_cache.sv
`timescale 1ns/1ps
module sim_desc_ring_cache;
  localparam int ADDR_W = 32, IDX_W = 4, CAP = 4, CNT_W = 3, RLEN = 10;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, consume = 0, flush = 0, rd_done = 0, wr_done = 0;
  logic [ADDR_W-1:0] cfg_base = 0;
  logic [IDX_W+3:0] cfg_len = 0;
  logic [IDX_W-1:0] cfg_head = 0, tail = 0, fmask = 0;
  logic rd_req, wr_req, cfg_err;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [CNT_W+3:0] rd_bytes, wr_bytes;
  logic [IDX_W-1:0] head;
  logic [CNT_W-1:0] unused, used;
  int n_chk = 0, n_bad = 0;
  bit done_all = 0;

  always #5 clk = ~clk;

  desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP(CAP)) u0 (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_base_i(cfg_base), .cfg_len_i(cfg_len),
    .cfg_head_i(cfg_head), .tail_i(tail), .consume_i(consume), .flush_i(flush),
    .flush_mask_i(fmask), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_bytes_o(rd_bytes),
    .rd_done_i(rd_done), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_bytes_o(wr_bytes),
    .wr_done_i(wr_done), .head_o(head), .unused_o(unused), .used_o(used), .cfg_err_o(cfg_err)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int base, int h, int t);
    cfg_we = 1; cfg_base = base; cfg_len = RLEN * 16; cfg_head = h; tail = t;
    tick();
    cfg_we = 0;
  endtask

  task automatic pulse_flush(int m);
    flush = 1; fmask = m; tick(); flush = 0;
  endtask

  task automatic consume_n(int n);
    for (int i = 0; i < n; i++) begin consume = 1; tick(); end
    consume = 0;
  endtask

  task automatic serve_rd(string tag, int a, int b, int hold);
    int w = 0;
    while (!rd_req && w < 10) begin tick(); w++; end
    chk({tag, " rd_req"}, rd_req, 1);
    if (!rd_req) return;
    chk({tag, " rd_addr"}, rd_addr, a);
    chk({tag, " rd_bytes"}, rd_bytes, b);
    for (int i = 0; i < hold; i++) begin
      tick();
      chk({tag, " R5 rd hold"}, rd_req && rd_addr == a && rd_bytes == b, 1);
    end
    rd_done = 1; tick(); rd_done = 0;
  endtask

  task automatic serve_wr(string tag, int a, int b);
    int w = 0;
    while (!wr_req && w < 10) begin tick(); w++; end
    chk({tag, " wr_req"}, wr_req, 1);
    if (!wr_req) return;
    chk({tag, " wr_addr"}, wr_addr, a);
    chk({tag, " wr_bytes"}, wr_bytes, b);
    wr_done = 1; tick(); wr_done = 0;
  endtask

  task automatic quiet(string tag, bit wr, int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (wr ? wr_req : rd_req) seen = 1;
    end
    chk(tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_ni = 1; tick();
    // R11 reset state
    chk("R11 rd_req", rd_req, 0);  chk("R11 wr_req", wr_req, 0);
    chk("R11 head", head, 0);      chk("R11 unused", unused, 0);
    chk("R11 used", used, 0);      chk("R11 err", cfg_err, 0);

    // R9 consume ignored with empty cache
    cfg('h1000, 0, 0);
    quiet("R4 no fetch at tail==ptr", 0, 3);
    consume_n(1); tick();
    chk("R9 ignored used", used, 0); chk("R9 ignored unused", unused, 0);

    // R1 R5 fetch, then R8 ignore of a non-smaller mask
    tail = 3;
    serve_rd("R1 fetch3", 'h1000, 48, 3);
    chk("R1 unused", unused, 3);
    consume_n(3);
    chk("R9 used", used, 3); chk("R9 unused", unused, 0);
    pulse_flush(1);
    chk("R6 masked wr_req", wr_req, 1);
    chk("R6 masked addr", wr_addr, 'h1000); chk("R6 masked bytes", wr_bytes, 32);
    pulse_flush(3);
    wr_done = 1; tick(); wr_done = 0;
    chk("R7 head", head, 2); chk("R7 used", used, 1);
    quiet("R8 larger mask ignored", 1, 4);
    chk("R8 used kept", used, 1);
    pulse_flush(0);
    serve_wr("R6 single", 'h1020, 16);
    chk("R7 head3", head, 3);

    // R8 pending writeback
    cfg('h1000, 0, 4);
    chk("R10 no err when idle", cfg_err, 0);
    serve_rd("R3 fetch4", 'h1000, 64, 0);
    consume_n(3);
    pulse_flush(1);
    chk("R8 first wr", wr_bytes, 32);
    pulse_flush(0);
    wr_done = 1; tick(); wr_done = 0;
    chk("R7 head after first", head, 2);
    serve_wr("R8 reissue", 'h1020, 16);
    chk("R8 head", head, 3); chk("R8 used", used, 0);

    // R2 wrap and R6 clamp
    cfg('h1000, 8, 2);
    serve_rd("R2 to end", 'h1080, 32, 0);
    serve_rd("R2 after wrap", 'h1000, 32, 0);
    chk("R2 unused", unused, 4);
    consume_n(4);
    pulse_flush(3);
    chk("R6 clamp bytes", wr_bytes, 32); chk("R6 clamp addr", wr_addr, 'h1080);
    wr_done = 1; tick(); wr_done = 0;
    chk("R7 head wraps", head, 0); chk("R7 used", used, 2);
    pulse_flush(3);
    quiet("R6 mask rounds to zero", 1, 4);
    pulse_flush(0);
    serve_wr("R6 rest", 'h1000, 32);
    chk("R7 head2", head, 2);

    // R10 illegal config changes
    cfg('h1000, 0, 3);
    serve_rd("R10 setup", 'h1000, 48, 0);
    consume_n(1);
    cfg('h3000, 5, 5);
    chk("R10 err used", cfg_err, 1);
    tick();
    chk("R10 err one cycle", cfg_err, 0);
    chk("R10 used clr", used, 0); chk("R10 unused clr", unused, 0);
    chk("R10 head load", head, 5);
    tail = 8; tick(); tick();
    chk("R10 fetch from new head", rd_req, 1);
    chk("R10 fetch addr", rd_addr, 'h3050);
    cfg('h3000, 0, 0);
    chk("R10 err busy", cfg_err, 1);
    chk("R10 req dropped", rd_req, 0);

    // R1 R2 R3 R4 fetch sweep
    for (int h = 0; h < RLEN; h++)
      for (int t = 0; t < RLEN; t++) begin
        int c;
        c = (t >= h) ? t - h : RLEN - h;
        if (c > CAP) c = CAP;
        cfg('h2000, h, t);
        if (c == 0) quiet($sformatf("R4 sweep h=%0d t=%0d", h, t), 0, 3);
        else serve_rd($sformatf("R1 R2 R3 sweep h=%0d t=%0d", h, t), 'h2000 + h * 16, c * 16, 0);
      end

    // R6 R7 writeback sweep
    for (int h = 0; h < RLEN; h++)
      for (int k = 1; k <= CAP; k++)
        for (int mi = 0; mi < 3; mi++) begin
          int m, e, w;
          m = (mi == 0) ? 0 : (mi == 1 ? 1 : 3);
          e = (h + k >= RLEN) ? RLEN - h : (m != 0 ? (k & ~m) : k);
          cfg('h4000, h, (h + k) % RLEN);
          w = 0;
          while (unused != k && w < 40) begin
            if (rd_req) begin rd_done = 1; tick(); rd_done = 0; end
            else tick();
            w++;
          end
          consume_n(k);
          chk($sformatf("R9 sweep used h=%0d k=%0d", h, k), used, k);
          pulse_flush(m);
          if (e == 0) quiet($sformatf("R6 sweep zero h=%0d k=%0d m=%0d", h, k, m), 1, 3);
          else begin
            serve_wr($sformatf("R6 sweep h=%0d k=%0d m=%0d", h, k, m), 'h4000 + h * 16, e * 16);
            chk($sformatf("R7 sweep head h=%0d k=%0d m=%0d", h, k, m), head, (h + e) % RLEN);
            chk($sformatf("R7 sweep used h=%0d k=%0d m=%0d", h, k, m), used, k - e);
          end
        end

    done_all = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule